// File: doc/BRIEF.md
# Two-Phase Stepper Motor Sequencer

This block produces the four winding control bits for a two-phase stepper motor in full-step, two-on excitation. At every instant two neighbouring windings are energised, which gives more holding torque than driving one winding at a time. The block walks a fixed four-entry excitation table, and one step is taken each time a programmable interval elapses.

A direction input chooses which way the table is walked. The reverse direction uses the same table read backwards, so a change of direction carries on from the current rotor position without a jump. An enable input starts and stops stepping. While stepping is stopped, the winding outputs hold their last pattern. A one-cycle strobe marks every step so that a position counter or a higher-level controller can follow the motor.

Top module: `stepper_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `winding` is 4'b1010 (table position 0) and `step_strobe` is 0.
- R2: `winding` always has exactly two bits set, and those two bits always form one of the four table patterns. Bit 3 is winding A1, bit 2 is A2, bit 1 is B1 and bit 0 is B2.
- R3: With `reverse` low, successive steps produce 1010, 0110, 0101, 1001, and the sequence then repeats.
- R4: With `reverse` high, successive steps produce 1001, 0101, 0110, 1010, and the sequence then repeats. This is the R3 table walked backwards.
- R5: While `enable` stays high, steps are `period`+1 cycles apart. The first step comes `period`+1 cycles after `enable` rises.
- R6: `period` is sampled each time the interval counter reloads, which is on every step and on every cycle with `enable` low. A new value takes effect from the next reload.
- R7: A change of `reverse` takes effect at the next step, which moves to the table neighbour of the current pattern in the new direction.
- R8: While `enable` is low, no step occurs, `winding` holds its value and `step_strobe` stays 0.
- R9: `step_strobe` is high for one cycle in exactly those cycles in which `winding` has just taken a new step value. `winding` never changes in any other cycle.
- R10: With `period` at 0, a step occurs in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Stepping runs while high |
| reverse | input | 1 | Selects the backward table walk |
| period | input | PERIOD_W | Step interval minus one, in clock cycles |
| winding | output | 4 | Winding drive bits, A1 A2 B1 B2 from MSB to LSB |
| step_strobe | output | 1 | One-cycle pulse on each step |

## Verification
The bench builds the block with the default 16-bit `period`, but it drives only values from 0 to 4. This keeps step intervals short, so a few thousand cycles cover several hundred steps, every table wrap in both directions and back-to-back steps at period 0. Random toggling of `enable` and `reverse` lands changes of either input right on a step boundary as well as in the middle of an interval. Directed phases pin the exact interval length, the reversal without a jump, and holding while disabled.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int STEPS = 4;
  localparam int IDX_W = $clog2(STEPS);
  localparam int COIL_W = 4;

  typedef logic [IDX_W-1:0]  pos_t;
  typedef logic [COIL_W-1:0] coil_t;

  // Two-on excitation, bit order A1 A2 B1 B2 (MSB..LSB)
  function automatic coil_t coil_pattern(input pos_t pos);
    coil_t c;
    case (pos)
      2'd0:    c = 4'b1010;
      2'd1:    c = 4'b0110;
      2'd2:    c = 4'b0101;
      default: c = 4'b1001;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] remain_q;

  assign tick = enable && (remain_q == '0);

  // Reload when idle or on expiry; otherwise count down
  always_ff @(posedge clk) begin
    if (rst)
      remain_q <= '0;
    else if (!enable || remain_q == '0)
      remain_q <= period;
    else
      remain_q <= remain_q - 1'b1;
  end
endmodule

// File: rtl/phase_walker.sv
module phase_walker
  import stepper_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic reverse,
  output pos_t pos_next
);
  pos_t pos_q;

  // Same table, walked up or down; wrap comes from the index width
  always_comb begin
    if (!advance)      pos_next = pos_q;
    else if (reverse)  pos_next = pos_q - 1'b1;
    else               pos_next = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_next;
  end
endmodule

// File: rtl/coil_driver.sv
module coil_driver
  import stepper_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  pos_t  pos_next,
  output coil_t winding,
  output logic  step_strobe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      winding     <= coil_pattern('0);
      step_strobe <= 1'b0;
    end else begin
      step_strobe <= load;
      if (load) winding <= coil_pattern(pos_next);
    end
  end
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                reverse,
  input  logic [PERIOD_W-1:0] period,
  output logic [3:0]          winding,
  output logic                step_strobe
);
  logic tick;
  pos_t pos_next;

  step_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst(rst), .enable(enable), .period(period), .tick(tick)
  );

  phase_walker u_walk (
    .clk(clk), .rst(rst), .advance(tick), .reverse(reverse), .pos_next(pos_next)
  );

  coil_driver u_drv (
    .clk(clk), .rst(rst), .load(tick), .pos_next(pos_next),
    .winding(winding), .step_strobe(step_strobe)
  );
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       reverse,
  input logic [3:0] winding,
  input logic       step_strobe
);
  function automatic logic [3:0] fwd_of(input logic [3:0] w);
    case (w)
      4'b1010: return 4'b0110;
      4'b0110: return 4'b0101;
      4'b0101: return 4'b1001;
      default: return 4'b1010;
    endcase
  endfunction

  function automatic logic [3:0] bwd_of(input logic [3:0] w);
    case (w)
      4'b1010: return 4'b1001;
      4'b1001: return 4'b0101;
      4'b0101: return 4'b0110;
      default: return 4'b1010;
    endcase
  endfunction

  a_r2_two_on: assert property (@(posedge clk) disable iff (rst)
    $countones(winding) == 2);

  a_r9_change_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(winding) |-> step_strobe);

  a_r8_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> !step_strobe);

  a_r3_forward_step: assert property (@(posedge clk) disable iff (rst)
    (step_strobe && !$past(reverse)) |-> winding == fwd_of($past(winding)));

  a_r4_reverse_step: assert property (@(posedge clk) disable iff (rst)
    (step_strobe && $past(reverse)) |-> winding == bwd_of($past(winding)));
endmodule

bind stepper_seq stepper_seq_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .reverse(reverse),
  .winding(winding), .step_strobe(step_strobe)
);

// File: tb/tb_stepper_seq.sv
`timescale 1ns/1ps
module tb_stepper_seq;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          reverse = 1'b0;
  logic [PW-1:0] period = '0;
  logic [3:0]    winding;
  logic          step_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stepper_seq #(.PERIOD_W(PW)) dut (
    .clk(clk), .rst(rst), .enable(enable), .reverse(reverse),
    .period(period), .winding(winding), .step_strobe(step_strobe)
  );

  // Expected pattern from the R3 table, position 0..3
  function automatic logic [3:0] exp_coil(input logic [1:0] p);
    case (p)
      2'd0: return 4'b1010;
      2'd1: return 4'b0110;
      2'd2: return 4'b0101;
      default: return 4'b1001;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: interval and position tracked from the requirements
  logic [PW-1:0] m_cnt;
  logic [1:0]    m_pos;
  logic          m_str;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_pos <= 2'd0; m_str <= 1'b0;
    end else begin
      m_str <= enable && (m_cnt == '0);
      if (!enable) m_cnt <= period;
      else if (m_cnt == '0) begin
        m_cnt <= period;
        m_pos <= reverse ? m_pos - 2'd1 : m_pos + 2'd1;
      end else m_cnt <= m_cnt - 1'b1;
    end
  end

  bit model_on = 1'b0;
  always @(negedge clk) begin
    if (model_on && !rst) begin
      check(winding == exp_coil(m_pos), "R3/R4 model pattern", {28'd0, winding}, {28'd0, exp_coil(m_pos)});
      check(step_strobe == m_str, "R9 model strobe", {31'd0, step_strobe}, {31'd0, m_str});
      check($countones(winding) == 2, "R2 two windings on", {28'd0, winding}, 32'd2);
    end
  end

  task automatic wait_step(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!step_strobe && n < 50);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [3:0] held;
    void'($urandom(32'd20240611));
    period = 16'd2;
    repeat (3) @(negedge clk);
    check(winding == 4'b1010, "R1 pattern in reset", {28'd0, winding}, 32'ha);
    rst = 1'b0;
    @(negedge clk);
    check(winding == 4'b1010, "R1 pattern after reset", {28'd0, winding}, 32'ha);
    check(step_strobe == 1'b0, "R1 strobe after reset", {31'd0, step_strobe}, 32'd0);
    model_on = 1'b1;

    // R5 / R3: forward steps with period 2
    enable = 1'b1;
    wait_step(n);
    check(n == 3, "R5 first step delay", n, 3);
    check(winding == 4'b0110, "R3 step 1", {28'd0, winding}, 32'h6);
    wait_step(n);
    check(n == 3, "R5 step spacing", n, 3);
    check(winding == 4'b0101, "R3 step 2", {28'd0, winding}, 32'h5);
    wait_step(n);
    check(winding == 4'b1001, "R3 step 3", {28'd0, winding}, 32'h9);
    wait_step(n);
    check(winding == 4'b1010, "R3 wrap", {28'd0, winding}, 32'ha);
    wait_step(n);
    check(winding == 4'b0110, "R3 step 1 again", {28'd0, winding}, 32'h6);

    // R7 / R4: reverse mid-stream, no jump
    reverse = 1'b1;
    wait_step(n);
    check(winding == 4'b1010, "R7 reversal neighbour", {28'd0, winding}, 32'ha);
    wait_step(n);
    check(winding == 4'b1001, "R4 reverse wrap", {28'd0, winding}, 32'h9);

    // R8: disabled holds
    enable = 1'b0;
    @(negedge clk);
    held = winding;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(winding == held, "R8 hold while disabled", {28'd0, winding}, {28'd0, held});
      check(!step_strobe, "R8 no strobe while disabled", {31'd0, step_strobe}, 32'd0);
    end

    // R10 / R6: period 0, reverse, steps every cycle
    period = 16'd0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(step_strobe && winding == 4'b0101, "R10 first cycle step", {28'd0, winding}, 32'h5);
    @(negedge clk);
    check(step_strobe && winding == 4'b0110, "R10 back to back", {28'd0, winding}, 32'h6);
    @(negedge clk);
    check(step_strobe && winding == 4'b1010, "R4 reverse sequence", {28'd0, winding}, 32'ha);

    // R6: longer period takes effect after next reload
    period = 16'd4;
    wait_step(n);
    check(n == 1, "R6 old period until reload", n, 1);
    wait_step(n);
    check(n == 5, "R6 new period after reload", n, 5);

    // Random mix checked by the reference
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 16 == 0) enable = ~enable;
      if ($urandom % 12 == 0) reverse = ~reverse;
      if ($urandom % 10 == 0) period = PW'($urandom % 5);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule